// File: doc/BRIEF.md
# SDRAM Inactivity Powerdown Controller

This block sits beside an SDRAM access sequencer. It watches for memory activity and lowers the clock enable of a chip-select region once that region has been idle for a selectable number of clocks. The region then stays in a data-retaining powerdown state, and no chip select is asserted to it, until the sequencer requests an access that targets it.

On such a request the block raises that region's clock enable at once. It then holds the grant low for a fixed, parameterised recovery delay before it lets the access through. Each region is tracked on its own, so a request to one region never wakes the other. A per-region status output reports the powerdown state to neighbouring logic, such as refresh scheduling.

Top module: `sdram_pd_ctrl`

## Requirements
- R1: While reset is held and after its release with no request, every `cke_o` bit and every `cs_n_o` bit is 1, every `pd_o` bit is 0 and `gnt_o` is 0.
- R2: With `tmo_sel_i` = 2'b01, a region enters powerdown on the clock edge that completes 64 consecutive idle edges. At that point its `cke_o` bit goes to 0 and its `pd_o` bit goes to 1.
- R3: With `tmo_sel_i` = 2'b10, a region enters powerdown on the clock edge that completes 128 consecutive idle edges.
- R4: With `tmo_sel_i` = 2'b00 or 2'b11, no region ever enters powerdown, however long it stays idle.
- R5: An edge on which `busy_i` is 1 restarts the idle count of every region. An edge on which `req_i` is 1 restarts the count only of the region selected by `req_rgn_i` (value 0 selects bit 0, value 1 selects bit 1).
- R6: An edge on which `tmo_sel_i` differs from its value at the previous edge restarts the idle count. The new timeout then applies in full from the next edge.
- R7: A request to a powered-down region raises that region's `cke_o` and clears its `pd_o` on the first edge. `gnt_o` stays 0 until WAKE_CYC (default 2) further edges have passed, and then rises.
- R8: Waking one region leaves the other region's `cke_o` at 0 and its `pd_o` at 1.
- R9: For a request to a region that is awake and not recovering, `gnt_o` follows `req_i` in the same cycle, with no stall.
- R10: `cs_n_o` has a 0 only in the bit of the region of a granted request. At most one bit is 0, and never a bit whose `cke_o` is 0.
- R11: `busy_i` does not wake a powered-down region; only a request does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Memory controller clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tmo_sel_i | input | 2 | Idle timeout select: 00 off, 01 short, 10 long, 11 off |
| busy_i | input | 1 | Controller is reading or writing the memory this cycle |
| req_i | input | 1 | Access request from the sequencer |
| req_rgn_i | input | RGN_W | Region targeted by the request |
| gnt_o | output | 1 | Request may proceed |
| cke_o | output | NUM_RGN | Per-region SDRAM clock enable |
| cs_n_o | output | NUM_RGN | Per-region active-low chip select for a granted access |
| pd_o | output | NUM_RGN | Per-region powerdown status |

## Verification
The checks assume that `req_rgn_i` names an existing region. They also assume the sequencer keeps `req_i` high until it sees `gnt_o`, so a rising grant always follows a request made earlier in the same wake-up. The bench drives only regions 0 and 1 and never drops a request during recovery. It changes `tmo_sel_i` only between measurements, or on one marked edge in the restart test, so every idle window it measures has a single unambiguous start.

// File: rtl/sdram_pd_pkg.sv
package sdram_pd_pkg;

  typedef enum logic [1:0] {
    TMO_OFF   = 2'b00,
    TMO_SHORT = 2'b01,
    TMO_LONG  = 2'b10,
    TMO_OFF_X = 2'b11
  } tmo_sel_e;

  typedef enum logic [1:0] {
    RG_ACT  = 2'b00,
    RG_PD   = 2'b01,
    RG_WAKE = 2'b10
  } rgn_state_e;

endpackage

// File: rtl/pd_idle_cnt.sv
module pd_idle_cnt #(
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] limit_m1_i,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q;

  assign expire_o = en_i && !clr_i && (cnt_q == limit_m1_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i || !en_i)     cnt_q <= '0;
    else if (expire_o)           cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/pd_region.sv
module pd_region
  import sdram_pd_pkg::*;
#(
  parameter int CNT_W    = 7,
  parameter int WAKE_CYC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tmo_en_i,
  input  logic             clr_i,
  input  logic             hit_i,
  input  logic [CNT_W-1:0] limit_m1_i,
  output logic             cke_o,
  output logic             pd_o,
  output logic             ready_o
);

  localparam int WK_W = (WAKE_CYC > 1) ? $clog2(WAKE_CYC) : 1;

  rgn_state_e      state_q, state_d;
  logic [WK_W-1:0] wk_q, wk_d;
  logic            expire;

  pd_idle_cnt #(.CNT_W(CNT_W)) u_idle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (tmo_en_i && (state_q == RG_ACT)),
    .clr_i     (clr_i || hit_i),
    .limit_m1_i(limit_m1_i),
    .expire_o  (expire)
  );

  always_comb begin
    state_d = state_q;
    wk_d    = wk_q;
    unique case (state_q)
      RG_ACT:  if (expire) state_d = RG_PD;
      RG_PD:   if (hit_i) begin
                 state_d = RG_WAKE;
                 wk_d    = '0;
               end
      RG_WAKE: if (wk_q == WK_W'(WAKE_CYC - 1)) state_d = RG_ACT;
               else                              wk_d    = wk_q + 1'b1;
      default: state_d = RG_ACT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RG_ACT;
      wk_q    <= '0;
    end else begin
      state_q <= state_d;
      wk_q    <= wk_d;
    end
  end

  assign cke_o   = (state_q != RG_PD);
  assign pd_o    = (state_q == RG_PD);
  assign ready_o = (state_q == RG_ACT);

endmodule

// File: rtl/sdram_pd_ctrl.sv
module sdram_pd_ctrl
  import sdram_pd_pkg::*;
#(
  parameter int NUM_RGN   = 2,
  parameter int SHORT_TMO = 64,
  parameter int LONG_TMO  = 128,
  parameter int WAKE_CYC  = 2,
  localparam int RGN_W    = (NUM_RGN > 1) ? $clog2(NUM_RGN) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         tmo_sel_i,
  input  logic               busy_i,
  input  logic               req_i,
  input  logic [RGN_W-1:0]   req_rgn_i,
  output logic               gnt_o,
  output logic [NUM_RGN-1:0] cke_o,
  output logic [NUM_RGN-1:0] cs_n_o,
  output logic [NUM_RGN-1:0] pd_o
);

  localparam int MAX_TMO = (LONG_TMO > SHORT_TMO) ? LONG_TMO : SHORT_TMO;
  localparam int CNT_W   = $clog2(MAX_TMO);

  logic [1:0]         tmo_q;
  logic               sel_chg;
  logic               tmo_en;
  logic [CNT_W-1:0]   limit_m1;
  logic [NUM_RGN-1:0] hit;
  logic [NUM_RGN-1:0] ready;
  logic               rgn_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tmo_q <= 2'b00;
    else         tmo_q <= tmo_sel_i;
  end

  assign sel_chg = (tmo_sel_i != tmo_q);

  always_comb begin
    tmo_en   = 1'b0;
    limit_m1 = '0;
    unique case (tmo_sel_e'(tmo_sel_i))
      TMO_SHORT: begin
        tmo_en   = 1'b1;
        limit_m1 = CNT_W'(SHORT_TMO - 1);
      end
      TMO_LONG: begin
        tmo_en   = 1'b1;
        limit_m1 = CNT_W'(LONG_TMO - 1);
      end
      default: ;
    endcase
  end

  for (genvar r = 0; r < NUM_RGN; r++) begin : g_rgn
    assign hit[r] = req_i && (int'(req_rgn_i) == r);

    pd_region #(.CNT_W(CNT_W), .WAKE_CYC(WAKE_CYC)) u_rgn (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tmo_en_i  (tmo_en),
      .clr_i     (busy_i || sel_chg),
      .hit_i     (hit[r]),
      .limit_m1_i(limit_m1),
      .cke_o     (cke_o[r]),
      .pd_o      (pd_o[r]),
      .ready_o   (ready[r])
    );

    assign cs_n_o[r] = ~(gnt_o && hit[r]);
  end

  assign rgn_ok = (int'(req_rgn_i) < NUM_RGN);
  assign gnt_o  = req_i && rgn_ok && |(hit & ready);

endmodule

// File: rtl/sdram_pd_chk.sv
module sdram_pd_chk #(
  parameter int NUM_RGN = 2,
  parameter int RGN_W   = 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [1:0]         tmo_sel_i,
  input logic               busy_i,
  input logic               req_i,
  input logic [RGN_W-1:0]   req_rgn_i,
  input logic               gnt_o,
  input logic [NUM_RGN-1:0] cke_o,
  input logic [NUM_RGN-1:0] cs_n_o,
  input logic [NUM_RGN-1:0] pd_o
);

  assert_cs_onehot_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n_o));

  assert_gnt_has_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_o |-> req_i);

  for (genvar r = 0; r < NUM_RGN; r++) begin : g_chk
    assert_cs_needs_cke_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cs_n_o[r] |-> cke_o[r]);

    assert_gnt_awake_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gnt_o && int'(req_rgn_i) == r) |-> (cke_o[r] && !pd_o[r]));

    assert_pd_entry_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pd_o[r]) |-> $past(!busy_i && (tmo_sel_i == 2'b01 || tmo_sel_i == 2'b10)));

    assert_wake_by_req_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(pd_o[r]) |-> $past(req_i && int'(req_rgn_i) == r));

    assert_wake_stall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(pd_o[r]) |-> !(gnt_o && int'(req_rgn_i) == r));
  end

endmodule

bind sdram_pd_ctrl sdram_pd_chk #(.NUM_RGN(NUM_RGN), .RGN_W(RGN_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tmo_sel_i(tmo_sel_i),
  .busy_i   (busy_i),
  .req_i    (req_i),
  .req_rgn_i(req_rgn_i),
  .gnt_o    (gnt_o),
  .cke_o    (cke_o),
  .cs_n_o   (cs_n_o),
  .pd_o     (pd_o)
);

// File: tb/sdram_pd_ctrl_test.sv
module sdram_pd_ctrl_test;

  localparam int W = 2;

  logic       clk = 1'b0;
  logic       rst_ni;
  logic [1:0] sel;
  logic       busy, req;
  logic [0:0] rgn;
  logic       gnt;
  logic [1:0] cke, cs_n, pd;
  int         checks = 0;
  int         fails  = 0;
  bit         done   = 1'b0;

  always #2 clk = ~clk;

  sdram_pd_ctrl #(.NUM_RGN(2), .SHORT_TMO(64), .LONG_TMO(128), .WAKE_CYC(W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .tmo_sel_i(sel), .busy_i(busy),
    .req_i(req), .req_rgn_i(rgn), .gnt_o(gnt), .cke_o(cke),
    .cs_n_o(cs_n), .pd_o(pd)
  );

  task automatic chk_eq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // restart counters with busy, then count idle edges until both regions drop
  task automatic measure(logic [1:0] s, int exp_k, string tag);
    int k;
    sel  = s;
    busy = 1'b1;
    step();
    step();
    busy = 1'b0;
    k = 0;
    while (cke != 2'b00 && k < 300) begin
      step();
      k++;
    end
    chk_eq(tag, k, exp_k);
  endtask

  task automatic wake(int r);
    req = 1'b1;
    rgn = 1'(r);
    #1;
    chk_eq("R7 no grant while asleep", int'(gnt), 0);
    step();
    chk_eq("R7 cke up on first edge", int'(cke[r]), 1);
    chk_eq("R7 pd clear on first edge", int'(pd[r]), 0);
    for (int i = 1; i <= W; i++) begin
      chk_eq("R7 grant stall", int'(gnt), 0);
      step();
    end
    chk_eq("R7 grant after recovery", int'(gnt), 1);
    chk_eq("R10 cs_n of granted region", int'(cs_n), (r == 0) ? 2 : 1);
    req = 1'b0;
    #1;
    chk_eq("R10 cs_n idle", int'(cs_n), 3);
    step();
  endtask

  initial begin
    int k, k0, k1;
    rst_ni = 1'b0; sel = 2'b00; busy = 1'b0; req = 1'b0; rgn = '0;
    repeat (3) step();
    chk_eq("R1 cke in reset", int'(cke), 3);
    chk_eq("R1 cs_n in reset", int'(cs_n), 3);
    chk_eq("R1 pd in reset", int'(pd), 0);
    rst_ni = 1'b1;
    step();
    chk_eq("R1 cke after reset", int'(cke), 3);
    chk_eq("R1 cs_n after reset", int'(cs_n), 3);
    chk_eq("R1 gnt after reset", int'(gnt), 0);

    // R4: timeout off, both encodings
    repeat (300) step();
    chk_eq("R4 sel 00 never sleeps", int'(cke), 3);
    measure(2'b11, 300, "R4 sel 11 idle edges");
    chk_eq("R4 sel 11 never sleeps", int'(pd), 0);

    // R2: short timeout
    measure(2'b01, 64, "R2 short timeout edges");
    chk_eq("R2 pd both", int'(pd), 3);
    chk_eq("R10 cs_n high in powerdown", int'(cs_n), 3);
    wake(0);
    chk_eq("R8 other region cke stays low", int'(cke[1]), 0);
    chk_eq("R8 other region pd stays high", int'(pd[1]), 1);
    wake(1);

    // R3: long timeout
    measure(2'b10, 128, "R3 long timeout edges");
    chk_eq("R3 pd both", int'(pd), 3);

    // R11: busy does not wake
    busy = 1'b1;
    repeat (10) step();
    busy = 1'b0;
    chk_eq("R11 busy keeps cke low", int'(cke), 0);
    chk_eq("R11 busy keeps pd high", int'(pd), 3);
    wake(0);
    wake(1);

    // R5: request restarts only its own region
    sel = 2'b01; busy = 1'b1;
    step(); step();
    busy = 1'b0;
    repeat (40) step();
    chk_eq("R5 awake after 40 idle", int'(cke), 3);
    req = 1'b1; rgn = 1'b0;
    #1;
    chk_eq("R9 immediate grant", int'(gnt), 1);
    chk_eq("R10 cs_n region 0", int'(cs_n), 2);
    step();
    req = 1'b0;
    k = 0; k0 = 0; k1 = 0;
    while (cke != 2'b00 && k < 300) begin
      step();
      k++;
      if (k1 == 0 && !cke[1]) k1 = k;
      if (k0 == 0 && !cke[0]) k0 = k;
    end
    chk_eq("R5 untouched region drops", k1, 23);
    chk_eq("R5 requested region restarted", k0, 64);

    // R5: busy restarts all regions
    wake(0);
    wake(1);
    busy = 1'b1; step(); busy = 1'b0;
    repeat (40) step();
    busy = 1'b1; step(); busy = 1'b0;
    k = 0;
    while (cke != 2'b00 && k < 300) begin
      step();
      k++;
    end
    chk_eq("R5 busy restart edges", k, 64);

    // R6: select change restarts with new timeout
    wake(0);
    wake(1);
    busy = 1'b1; step(); busy = 1'b0;
    repeat (50) step();
    chk_eq("R6 awake before change", int'(cke), 3);
    sel = 2'b10;
    step();
    k = 0;
    while (cke != 2'b00 && k < 300) begin
      step();
      k++;
    end
    chk_eq("R6 edges after select change", k, 128);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule